// File: doc/BRIEF.md
# Bus Transfer Port-Size Beat Splitter

The block accepts one transfer request from a bus master and turns it into the sequence of data beats that a slave port needs. The slave port can be 1, 2, 4 or 8 bytes wide. A request carries a 32-bit address, a 3-bit size code, a direction flag and up to 32 bytes of write data. The block issues one beat after another at port-aligned addresses. Each beat has its own byte-lane enables and its own steered write data. Read bytes returned by the slave are collected into a single 256-bit response.

Short transfers of one to four bytes may start at any byte, as long as they stay inside one 4-byte word. A request that would leave its word is refused with an error pulse. Longer transfers of one to four doublewords are also handled, and so is a full 32-byte line. Every beat waits for a slave acknowledge, so a slow slave can stall it for as long as it likes. A second request can be taken while the first is still moving data, so the address phase of the next transfer overlaps the data phase of the current one.

Top module: `beat_splitter`

## Requirements
- R1: Size codes 0, 1, 2 and 3 mean 1, 2, 3 and 4 bytes, accepted at any byte offset that keeps every byte inside one aligned 4-byte word. Codes 4, 5, 6 and 7 mean 8, 16, 24 and 32 bytes.
- R2: A request with code 0 to 3 whose bytes would cross a 4-byte word boundary is rejected. `reqErr` is high for one cycle, in the cycle after the accepting edge, and no beat and no `rspDone` follow.
- R3: Beats go to ascending addresses. The first is the transfer start rounded down to the port width, and each next one adds the port width in bytes. The count is the smallest number of beats that covers every requested byte.
- R4: Port width code 0, 1, 2 or 3 selects 1, 2, 4 or 8 bytes. Bit j of `beatBe` is set only when j is below the port byte count and address `beatAddr`+j is a requested byte.
- R5: On writes, byte lane j of `beatWdata` carries byte number (`beatAddr`+j−base) of `reqWdata`, where base is the start rounded down to 8 bytes. Disabled lanes are zero.
- R6: On reads, lane j of `slvRdata` at an acknowledge is stored as byte (`beatAddr`+j−base) of `rspRdata`. Bytes outside the request read as zero, and a write response is all zero.
- R7: `rspDone` is high for one cycle, in the cycle after the edge that samples the last beat's acknowledge, and `rspRdata` holds the finished response in that cycle.
- R8: For codes 4 to 6 the start is the address rounded down to 8 bytes. For code 7 it is the address rounded down to 32 bytes, and the four doublewords follow in ascending order.
- R9: While `slvAck` is low, a beat stays presented with unchanged address, enables and data, for any number of cycles.
- R10: One further request is accepted while a transfer is in progress. `reqReady` is low while that request is held, and the held request's first beat is presented in the cycle after the previous transfer's last acknowledge.
- R11: After reset, `reqReady` is high, and `beatValid`, `rspDone` and `reqErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portWidth | input | 2 | Slave port width code: 1, 2, 4 or 8 bytes |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken this cycle |
| reqAddr | input | 32 | Request byte address |
| reqSize | input | 3 | Size code |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 256 | Write bytes, byte 0 at the base doubleword address |
| reqErr | output | 1 | Pulse: request refused for crossing a word |
| beatValid | output | 1 | A beat is presented to the slave |
| beatAddr | output | 32 | Port-aligned beat address |
| beatBe | output | 8 | Byte-lane enables of the beat |
| beatWrite | output | 1 | Direction of the beat |
| beatWdata | output | 64 | Steered write data of the beat |
| slvAck | input | 1 | Slave accepts or completes the presented beat |
| slvRdata | input | 64 | Slave read data, lane j at bits 8j+7 to 8j |
| rspDone | output | 1 | Pulse: transfer finished |
| rspRdata | output | 256 | Assembled read response |

## Verification
The assertions assume two things about the inputs. `portWidth` never changes while a beat is presented or a request is held. `slvAck` is only raised while `beatValid` is high. The stimulus changes the width only between scenarios, after the previous response has arrived. Its slave model raises the acknowledge only on a presented beat, after the chosen number of stall cycles. Requests are held for a single accepting edge, so each request is taken exactly once.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int ADDR_W     = 32;
  localparam int BUS_BYTES  = 8;
  localparam int LINE_BYTES = 32;
  localparam int WORD_BYTES = 4;
  localparam int SIZE_W     = 3;
  localparam int PW_W       = 2;
  localparam int BUS_W      = BUS_BYTES * 8;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES) + 1;
  localparam int LANE_W     = $clog2(BUS_BYTES);
  localparam int WORD_LSB   = $clog2(WORD_BYTES);

  typedef struct packed {
    logic loadAct;
    logic loadPend;
    logic promote;
    logic step;
    logic capture;
    logic finish;
  } bspStrobe_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [OFF_W-1:0]  off;
    logic [OFF_W-1:0]  endOff;
    logic              write;
    logic [LINE_W-1:0] wdata;
  } bspReq_t;

  function automatic logic [OFF_W-1:0] sizeToBytes(input logic [SIZE_W-1:0] code);
    if (code < SIZE_W'(4)) return OFF_W'(code) + OFF_W'(1);
    return OFF_W'(code - SIZE_W'(3)) << LANE_W;
  endfunction
endpackage

// File: rtl/bsp_ctrl.sv
module bsp_ctrl
  import bsp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqBad,
  input  logic       slvAck,
  input  logic       lastBeat,
  output bspStrobe_t strb,
  output logic       reqReady,
  output logic       beatValid,
  output logic       rspDone,
  output logic       reqErr
);
  logic actValid, pendValid, accept, good, finishing;

  assign reqReady  = !pendValid;
  assign accept    = reqValid && reqReady;
  assign good      = accept && !reqBad;
  assign beatValid = actValid;
  assign finishing = actValid && slvAck && lastBeat;

  always_comb begin
    strb.loadAct  = good && (!actValid || finishing);
    strb.loadPend = good && actValid && !finishing;
    strb.promote  = finishing && pendValid;
    strb.step     = actValid && slvAck && !lastBeat;
    strb.capture  = actValid && slvAck;
    strb.finish   = finishing;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actValid  <= 1'b0;
      pendValid <= 1'b0;
      rspDone   <= 1'b0;
      reqErr    <= 1'b0;
    end else begin
      actValid  <= finishing ? (pendValid || strb.loadAct) : (actValid || strb.loadAct);
      pendValid <= strb.promote ? 1'b0 : (pendValid || strb.loadPend);
      rspDone   <= finishing;
      reqErr    <= accept && reqBad;
    end
  end

  // R10: a held request always sits behind an active one
  a_r10_pend_behind_act: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> actValid);

  // R10: a held request stays held until the active transfer ends
  a_r10_pend_kept: assert property (@(posedge clk) disable iff (!rstN)
    pendValid && !finishing |=> pendValid);

  // R2: a refused request on an idle block starts nothing
  a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rstN)
    accept && reqBad && !actValid |=> !actValid);
endmodule

// File: rtl/bsp_datapath.sv
module bsp_datapath
  import bsp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bspStrobe_t        strb,
  input  logic [PW_W-1:0]   portWidth,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqWdata,
  input  logic [BUS_W-1:0]  slvRdata,
  output logic              reqBad,
  output logic              lastBeat,
  output logic              actWrite,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [BUS_BYTES-1:0] beatBe,
  output logic [BUS_W-1:0]  beatWdata,
  output logic [LINE_W-1:0] rspRdata
);
  logic [OFF_W-1:0]  incBytes, portBytes, portMask, incRel, actRel;
  logic [ADDR_W-1:0] incStart;
  bspReq_t           incReq, actReq, pendReq;
  logic [LINE_W-1:0] asmData, asmNext;

  always_comb begin
    incBytes  = sizeToBytes(reqSize);
    portBytes = OFF_W'(1) << portWidth;
    portMask  = portBytes - OFF_W'(1);
    if (reqSize == SIZE_W'(7))      incStart = reqAddr & ~ADDR_W'(LINE_BYTES - 1);
    else if (reqSize >= SIZE_W'(4)) incStart = reqAddr & ~ADDR_W'(BUS_BYTES - 1);
    else                            incStart = reqAddr;
    incReq.base   = incStart & ~ADDR_W'(BUS_BYTES - 1);
    incReq.off    = OFF_W'(incStart[LANE_W-1:0]);
    incReq.endOff = incReq.off + incBytes;
    incReq.write  = reqWrite;
    incReq.wdata  = reqWdata;
    incRel        = incReq.off & ~portMask;
    reqBad = (reqSize < SIZE_W'(4)) &&
             ((OFF_W'(reqAddr[WORD_LSB-1:0]) + incBytes) > OFF_W'(WORD_BYTES));
  end

  assign lastBeat = ({1'b0, actRel} + {1'b0, portBytes}) >= {1'b0, actReq.endOff};
  assign beatAddr = actReq.base + ADDR_W'(actRel);
  assign actWrite = actReq.write;

  // per-lane enable, write steering and read placement
  always_comb begin
    logic [OFF_W-1:0] laneOff;
    asmNext   = asmData;
    beatWdata = '0;
    beatBe    = '0;
    laneOff   = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      laneOff   = actRel + OFF_W'(j);
      beatBe[j] = (OFF_W'(j) < portBytes) && (laneOff >= actReq.off) &&
                  (laneOff < actReq.endOff);
      if (beatBe[j]) begin
        beatWdata[j*8 +: 8] = actReq.wdata[laneOff[OFF_W-2:0]*8 +: 8];
        asmNext[laneOff[OFF_W-2:0]*8 +: 8] = slvRdata[j*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actReq   <= '0;
      pendReq  <= '0;
      actRel   <= '0;
      asmData  <= '0;
      rspRdata <= '0;
    end else begin
      if (strb.loadAct) begin
        actReq <= incReq;
        actRel <= incRel;
      end else if (strb.promote) begin
        actReq <= pendReq;
        actRel <= pendReq.off & ~portMask;
      end else if (strb.step) begin
        actRel <= actRel + portBytes;
      end
      if (strb.loadPend) pendReq <= incReq;
      if (strb.finish) begin
        rspRdata <= actReq.write ? '0 : asmNext;
        asmData  <= '0;
      end else if (strb.capture && !actReq.write) begin
        asmData <= asmNext;
      end
    end
  end
endmodule

// File: rtl/beat_splitter.sv
module beat_splitter
  import bsp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PW_W-1:0]   portWidth,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqWdata,
  output logic              reqErr,
  output logic              beatValid,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [BUS_BYTES-1:0] beatBe,
  output logic              beatWrite,
  output logic [BUS_W-1:0]  beatWdata,
  input  logic              slvAck,
  input  logic [BUS_W-1:0]  slvRdata,
  output logic              rspDone,
  output logic [LINE_W-1:0] rspRdata
);
  bspStrobe_t strb;
  logic reqBad, lastBeat;

  bsp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBad(reqBad),
    .slvAck(slvAck), .lastBeat(lastBeat), .strb(strb), .reqReady(reqReady),
    .beatValid(beatValid), .rspDone(rspDone), .reqErr(reqErr)
  );

  bsp_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .portWidth(portWidth),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .slvRdata(slvRdata), .reqBad(reqBad),
    .lastBeat(lastBeat), .actWrite(beatWrite), .beatAddr(beatAddr),
    .beatBe(beatBe), .beatWdata(beatWdata), .rspRdata(rspRdata)
  );

  logic [BUS_BYTES-1:0] laneMask;
  logic [ADDR_W-1:0]    addrMask;
  assign laneMask = BUS_BYTES'(((BUS_BYTES+1)'(1) << ((LANE_W+1)'(1) << portWidth)) - (BUS_BYTES+1)'(1));
  assign addrMask = ADDR_W'(((LANE_W+1)'(1) << portWidth) - (LANE_W+1)'(1));

  // R4: every beat enables at least one lane and none beyond the port
  a_r4_be_in_port: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> (beatBe != '0) && ((beatBe & ~laneMask) == '0));

  // R3: beat addresses sit on port-width boundaries
  a_r3_beat_aligned: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> (beatAddr & addrMask) == '0);

  // R9: a stalled beat is held unchanged
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !slvAck |=> beatValid && $stable(beatAddr) && $stable(beatBe) &&
                             $stable(beatWdata));
endmodule

// File: tb/beat_splitter_tb_top.sv
module beat_splitter_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   portWidth = 2'd0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [31:0]  reqAddr = '0;
  logic [2:0]   reqSize = '0;
  logic         reqWrite = 1'b0;
  logic [255:0] reqWdata = '0;
  logic         reqErr;
  logic         beatValid;
  logic [31:0]  beatAddr;
  logic [7:0]   beatBe;
  logic         beatWrite;
  logic [63:0]  beatWdata;
  logic         slvAck = 1'b0;
  logic [63:0]  slvRdata = '0;
  logic         rspDone;
  logic [255:0] rspRdata;

  beat_splitter dut_i (
    .clk(clk), .rstN(rstN), .portWidth(portWidth), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqErr(reqErr),
    .beatValid(beatValid), .beatAddr(beatAddr), .beatBe(beatBe),
    .beatWrite(beatWrite), .beatWdata(beatWdata), .slvAck(slvAck),
    .slvRdata(slvRdata), .rspDone(rspDone), .rspRdata(rspRdata)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit ended = 1'b0;
  int stallCfg = 0, waitCnt = 0, stallErr = 0;
  logic [31:0] heldAddr = '0;
  int logN = 0;
  logic [31:0] logAddr [64];
  logic [7:0]  logBe   [64];
  logic [63:0] logData [64];
  int          logCyc  [64];
  int doneCnt = 0, doneCyc = 0, errCnt = 0;
  logic [255:0] lastRsp = '0;

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] wByte(input int seed, input int k);
    return 8'(seed + 3 * k);
  endfunction

  // slave model and observers, all away from the rising edge
  always @(negedge clk) begin
    if (beatValid) begin
      if (waitCnt > 0 && beatAddr != heldAddr) stallErr++;
      heldAddr = beatAddr;
      if (waitCnt >= stallCfg) begin
        slvAck = 1'b1;
        for (int j = 0; j < 8; j++)
          slvRdata[j*8 +: 8] = (j < (1 << portWidth)) ? memByte(beatAddr + 32'(j)) : 8'hEE;
        if (logN < 64) begin
          logAddr[logN] = beatAddr;
          logBe[logN]   = beatBe;
          logData[logN] = beatWdata;
          logCyc[logN]  = cyc;
          logN++;
        end
        waitCnt = 0;
      end else begin
        slvAck = 1'b0;
        waitCnt++;
      end
    end else begin
      slvAck  = 1'b0;
      waitCnt = 0;
    end
    if (rspDone) begin
      doneCnt++;
      doneCyc = cyc;
      lastRsp = rspRdata;
    end
    if (reqErr) errCnt++;
  end

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic sendReq(input logic [31:0] a, input logic [2:0] sz, input logic wr, input int seed);
    int t;
    @(negedge clk);
    reqAddr  = a;
    reqSize  = sz;
    reqWrite = wr;
    for (int k = 0; k < 32; k++) reqWdata[k*8 +: 8] = wByte(seed, k);
    reqValid = 1'b1;
    t = 0;
    while (!reqReady && t < 1000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input int target, input string tag);
    int t;
    t = 0;
    while (doneCnt < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(doneCnt >= target, tag, $sformatf("done count %0d expected %0d", doneCnt, target));
  endtask

  // issue one transfer, then compare beats and response with values from the requirements
  task automatic runCase(input string tag, input logic [31:0] a, input logic [2:0] sz,
                         input logic wr, input logic [1:0] pw, input int stall, input int seed);
    int n, p, k, d0;
    logic [31:0] s, base, ad;
    logic [7:0] be;
    logic [63:0] expW, msk;
    logic [255:0] expR;
    @(negedge clk);
    portWidth = pw;
    stallCfg  = stall;
    logN      = 0;
    stallErr  = 0;
    d0        = doneCnt;
    sendReq(a, sz, wr, seed);
    waitDone(d0 + 1, tag);
    n = (sz < 3'd4) ? int'(sz) + 1 : (int'(sz) - 3) * 8;
    if (sz == 3'd7)      s = a & ~32'h1F;
    else if (sz >= 3'd4) s = a & ~32'h7;
    else                 s = a;
    base = s & ~32'h7;
    p = 1 << pw;
    ad = s & ~32'(p - 1);
    k = 0;
    while (ad < s + 32'(n)) begin
      be = '0;
      expW = '0;
      msk = '0;
      for (int j = 0; j < p; j++)
        if (ad + 32'(j) >= s && ad + 32'(j) < s + 32'(n)) begin
          be[j] = 1'b1;
          msk[j*8 +: 8] = 8'hFF;
          expW[j*8 +: 8] = wByte(seed, int'(ad + 32'(j) - base));
        end
      if (k < logN) begin
        check(logAddr[k] == ad, "R3", $sformatf("%s beat %0d addr %h expected %h", tag, k, logAddr[k], ad));
        check(logBe[k] == be, "R4", $sformatf("%s beat %0d be %h expected %h", tag, k, logBe[k], be));
        if (wr)
          check((logData[k] & msk) == expW, "R5",
                $sformatf("%s beat %0d wdata %h expected %h", tag, k, logData[k] & msk, expW));
      end
      k++;
      ad = ad + 32'(p);
    end
    check(logN == k, "R3", $sformatf("%s beat count %0d expected %0d", tag, logN, k));
    for (int i = 0; i < 32; i++)
      expR[i*8 +: 8] = (!wr && base + 32'(i) >= s && base + 32'(i) < s + 32'(n)) ?
                       memByte(base + 32'(i)) : 8'h00;
    check(lastRsp == expR, "R6", $sformatf("%s response %h expected %h", tag, lastRsp, expR));
    if (logN > 0)
      check(doneCyc == logCyc[logN-1] + 1, "R7",
            $sformatf("%s done cycle %0d expected %0d", tag, doneCyc, logCyc[logN-1] + 1));
    if (stall > 0)
      check(stallErr == 0, "R9", $sformatf("%s stalled address changes %0d expected 0", tag, stallErr));
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R11", $sformatf("reqReady %0b expected 1", reqReady));
    check(beatValid == 1'b0, "R11", $sformatf("beatValid %0b expected 0", beatValid));
    check(rspDone == 1'b0, "R11", $sformatf("rspDone %0b expected 0", rspDone));
    check(reqErr == 1'b0, "R11", $sformatf("reqErr %0b expected 0", reqErr));
  endtask

  task automatic testSmallWide();
    runCase("R1 byte on 8-byte port", 32'h1005, 3'd0, 1'b0, 2'd3, 0, 8'h11);
    check(logN == 1 && logBe[0] == 8'h20, "R1", $sformatf("beats %0d be %h expected 1 and 20", logN, logBe[0]));
  endtask

  task automatic testOddWrite();
    runCase("R1 three bytes write on 4-byte port", 32'h2001, 3'd2, 1'b1, 2'd2, 0, 8'h40);
    check(logN == 1 && logBe[0] == 8'h0E, "R1", $sformatf("beats %0d be %h expected 1 and 0e", logN, logBe[0]));
  endtask

  task automatic testNarrowReads();
    runCase("R3 word read on byte port", 32'h3004, 3'd3, 1'b0, 2'd0, 0, 8'h00);
    runCase("R4 three bytes on 2-byte port", 32'h4005, 3'd2, 1'b0, 2'd1, 1, 8'h00);
  endtask

  task automatic testBursts();
    runCase("R8 line read on 8-byte port", 32'h5013, 3'd7, 1'b0, 2'd3, 0, 8'h00);
    check(logAddr[0] == 32'h5000, "R8", $sformatf("line start %h expected 5000", logAddr[0]));
    runCase("R8 line write on 4-byte port", 32'h5127, 3'd7, 1'b1, 2'd2, 0, 8'h77);
    runCase("R9 three doublewords on 2-byte port stalled", 32'h600C, 3'd6, 1'b0, 2'd1, 3, 8'h00);
    check(logAddr[0] == 32'h6008, "R8", $sformatf("multi start %h expected 6008", logAddr[0]));
  endtask

  task automatic testReject();
    int e0, d0;
    @(negedge clk);
    portWidth = 2'd3;
    logN = 0;
    e0 = errCnt;
    d0 = doneCnt;
    sendReq(32'h0103, 3'd1, 1'b0, 0);
    sendReq(32'h0202, 3'd2, 1'b1, 0);
    repeat (6) @(negedge clk);
    check(errCnt == e0 + 2, "R2", $sformatf("error pulses %0d expected %0d", errCnt - e0, 2));
    check(logN == 0, "R2", $sformatf("beats after refusal %0d expected 0", logN));
    check(doneCnt == d0, "R2", $sformatf("done pulses after refusal %0d expected 0", doneCnt - d0));
  endtask

  task automatic testPipeline();
    int d0;
    logic [255:0] expR;
    @(negedge clk);
    portWidth = 2'd0;
    stallCfg = 0;
    logN = 0;
    d0 = doneCnt;
    sendReq(32'h7000, 3'd4, 1'b0, 0);
    sendReq(32'h7102, 3'd1, 1'b0, 0);
    check(reqReady == 1'b0, "R10", $sformatf("reqReady with held request %0b expected 0", reqReady));
    waitDone(d0 + 2, "R10");
    check(logN == 10, "R10", $sformatf("total beats %0d expected 10", logN));
    check(logAddr[8] == 32'h7102, "R10", $sformatf("held first beat %h expected 7102", logAddr[8]));
    check(logCyc[8] == logCyc[7] + 1, "R10",
          $sformatf("held first beat cycle %0d expected %0d", logCyc[8], logCyc[7] + 1));
    expR = '0;
    expR[2*8 +: 8] = memByte(32'h7102);
    expR[3*8 +: 8] = memByte(32'h7103);
    check(lastRsp == expR, "R6", $sformatf("held response %h expected %h", lastRsp, expR));
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!ended) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSmallWide();
    testOddWrite();
    testNarrowReads();
    testBursts();
    testReject();
    testPipeline();
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule